// File: doc/BRIEF.md
# Line-Framed Image Data Serializer

This block generates a synthetic image-frame stream for exercising an image acquisition path. It drives three source-synchronous lines: a serial data line, a one-bit-time sync pulse marking the start of each line, and a bit clock that toggles on every system clock cycle. Each data bit is held for exactly one system clock cycle, which is half a period of the bit clock. Bits go out most significant bit first, one 16-bit word after another.

A frame is a grid of line slots. A new slot starts every `LINE_CYCLES` system clocks, and the frame repeats every `LINE_SLOTS` slots (10 ms at the defaults). The first `IMG_LINES + TRAILER_LINES` slots are active. The first active line opens with two header check words, 0xFAF3 then 0xEB90. Then comes its share of the image payload. The image lines carry a running image count. The trailer lines carry two trailer check words, 0x050C then 0x146F, followed by `INFO_WORDS` information words that count down, and then zero fill. In each active line the data line stays low after the last word until the next slot begins. The inactive slots are silent.

A frame-start flag marks the first bit of every frame so that a bench can align to the stream. When the enable input is low, all outputs except the bit clock stay quiet. Setting it again starts a new frame from the header.

Top module: `lf_image_serializer`

## Requirements
- R1: While rst_ni is low, ser_data_o, word_sync_o, frame_start_o and bit_clk_o are all 0.
- R2: bit_clk_o inverts on every system clock edge out of reset, whatever the state of en_i or of the frame.
- R3: word_sync_o is high for exactly one cycle at the start of each active line slot (the first IMG_LINES+TRAILER_LINES of LINE_SLOTS slots), and in that same cycle ser_data_o carries the MSB of the line's first word. Line slots are LINE_CYCLES cycles apart.
- R4: The first active line begins with header words 0xFAF3 then 0xEB90, sent MSB first at one bit per cycle, followed by WORDS_PER_LINE image words.
- R5: Each image line carries WORDS_PER_LINE image words. Image words take successive values from 0 up to IMG_LAST and then wrap to 0. The count continues across frames.
- R6: The trailer lines carry TRAILER_LINES*WORDS_PER_LINE words in order: 0x050C, 0x146F, then INFO_WORDS information words, then zeros. The information words count down from INFO_FIRST to 0, wrap back to INFO_FIRST, and continue across frames.
- R7: ser_data_o is 0 in every cycle that does not carry a word bit: after the last word of a line and throughout the inactive slots.
- R8: frame_start_o is high for one cycle at the first sync of each frame. It coincides with word_sync_o and repeats every LINE_SLOTS*LINE_CYCLES cycles.
- R9: A cycle with en_i low yields 0 on ser_data_o, word_sync_o and frame_start_o and returns the line timing to the frame start. When en_i is set again, a frame begins with the header at once, and the image and information counts resume from where they stopped.
- R10: Reset reloads the image count to 0 and the information count to INFO_FIRST, so the first frame after reset repeats the initial sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one data bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the generator at frame start |
| ser_data_o | output | 1 | Serial data, MSB first |
| word_sync_o | output | 1 | One-cycle pulse with the first bit of each active line |
| bit_clk_o | output | 1 | Free-running bit clock, half the system clock rate |
| frame_start_o | output | 1 | One-cycle pulse with the first bit of each frame |

## Verification
On every cycle, the assertions check that the bit clock toggles, that each sync pulse lasts a single cycle, that the frame flag only appears together with a sync, that a disabled cycle leaves the outputs quiet, that the line counter wraps at the slot boundary, and that the data line is low between words. The word contents can only be shown by the bench scenarios. These are the header and trailer check words, the image count wrapping at its limit, the downward information count wrapping and persisting across frames, and the counts resuming after a pause in enable or restarting after a mid-frame reset. The bench compares every output bit against a cycle-by-cycle model of the frame.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int WORD_W    = 16;
  localparam int BIT_IDX_W = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t HDR_WORD_A = 16'hFAF3;
  localparam word_t HDR_WORD_B = 16'hEB90;
  localparam word_t TRL_WORD_A = 16'h050C;
  localparam word_t TRL_WORD_B = 16'h146F;

  typedef enum logic [2:0] {
    K_HDR0,
    K_HDR1,
    K_IMG,
    K_CHK0,
    K_CHK1,
    K_INFO,
    K_ZERO
  } word_kind_e;
endpackage

// File: rtl/lf_line_timer.sv
module lf_line_timer #(
  parameter int LINE_CYCLES = 3000,
  parameter int LINE_SLOTS  = 160,
  localparam int CW = $clog2(LINE_CYCLES),
  localparam int LW = $clog2(LINE_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [CW-1:0] cyc_o,
  output logic [LW-1:0] line_o
);
  localparam logic [CW-1:0] CYC_LAST  = CW'(LINE_CYCLES - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINE_SLOTS - 1);

  logic [CW-1:0] cyc_q;
  logic [LW-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      line_q <= '0;
    end else if (!en_i) begin
      cyc_q  <= '0;
      line_q <= '0;
    end else if (cyc_q == CYC_LAST) begin
      cyc_q  <= '0;
      line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign cyc_o  = cyc_q;
  assign line_o = line_q;

  // R3: slot boundary restarts the bit count and moves to the next slot
  p_line_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cyc_q == CYC_LAST) |=> (cyc_q == '0 && line_q != $past(line_q)));

  // R9: disable returns timing to frame start
  p_hold_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cyc_q == '0 && line_q == '0));
endmodule

// File: rtl/lf_word_source.sv
module lf_word_source
  import lf_pkg::*;
#(
  parameter int IMG_LAST   = 'h4000,
  parameter int INFO_FIRST = 'h0100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  word_kind_e kind_i,
  output word_t      word_o
);
  localparam word_t IMG_LAST_W   = word_t'(IMG_LAST);
  localparam word_t INFO_FIRST_W = word_t'(INFO_FIRST);

  word_t img_q, info_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      img_q  <= '0;
      info_q <= INFO_FIRST_W;
    end else if (load_i) begin
      case (kind_i)
        K_IMG:   img_q  <= (img_q == IMG_LAST_W) ? '0 : img_q + 1'b1;
        K_INFO:  info_q <= (info_q == '0) ? INFO_FIRST_W : info_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (kind_i)
      K_HDR0:  word_o = HDR_WORD_A;
      K_HDR1:  word_o = HDR_WORD_B;
      K_IMG:   word_o = img_q;
      K_CHK0:  word_o = TRL_WORD_A;
      K_CHK1:  word_o = TRL_WORD_B;
      K_INFO:  word_o = info_q;
      default: word_o = '0;
    endcase
  end

  // R6: info count moves only when an info word is consumed
  p_info_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && kind_i == K_INFO) |=> $stable(info_q));

  // R5: image count moves only when an image word is consumed
  p_img_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && kind_i == K_IMG) |=> $stable(img_q));
endmodule

// File: rtl/lf_bit_shifter.sv
module lf_bit_shifter
  import lf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  shift_i,
  input  word_t word_i,
  output logic  bit_o
);
  word_t sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_o <= 1'b0;
    end else if (load_i) begin
      bit_o <= word_i[WORD_W-1];
      sr_q  <= {word_i[WORD_W-2:0], 1'b0};
    end else if (shift_i) begin
      bit_o <= sr_q[WORD_W-1];
      sr_q  <= {sr_q[WORD_W-2:0], 1'b0};
    end else begin
      bit_o <= 1'b0;
    end
  end

  // R7: no word bit in flight means a low line
  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> !bit_o);
endmodule

// File: rtl/lf_image_serializer.sv
module lf_image_serializer
  import lf_pkg::*;
#(
  parameter int WORDS_PER_LINE = 128,
  parameter int IMG_LINES      = 128,
  parameter int TRAILER_LINES  = 2,
  parameter int LINE_SLOTS     = 160,
  parameter int LINE_CYCLES    = 3000,
  parameter int INFO_WORDS     = 202,
  parameter int IMG_LAST       = 'h4000,
  parameter int INFO_FIRST     = 'h0100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic ser_data_o,
  output logic word_sync_o,
  output logic bit_clk_o,
  output logic frame_start_o
);
  localparam int CW         = $clog2(LINE_CYCLES);
  localparam int LW         = $clog2(LINE_SLOTS);
  localparam int ACT_LINES  = IMG_LINES + TRAILER_LINES;
  localparam int HDR_WORDS  = 2;
  localparam int INFO_END   = HDR_WORDS + INFO_WORDS;

  logic [CW-1:0]           cyc;
  logic [LW-1:0]           line;
  logic [CW-BIT_IDX_W-1:0] widx;
  logic [BIT_IDX_W-1:0]    boff;
  int                      line_n, widx_n, nwords, tidx;
  logic                    act_line, in_word, load;
  word_kind_e              kind;
  word_t                   word;

  lf_line_timer #(
    .LINE_CYCLES(LINE_CYCLES),
    .LINE_SLOTS (LINE_SLOTS)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .cyc_o (cyc),
    .line_o(line)
  );

  assign widx = cyc[CW-1:BIT_IDX_W];
  assign boff = cyc[BIT_IDX_W-1:0];

  always_comb begin
    line_n   = int'(line);
    widx_n   = int'(widx);
    act_line = line_n < ACT_LINES;
    nwords   = (line_n == 0) ? WORDS_PER_LINE + HDR_WORDS : WORDS_PER_LINE;
    in_word  = en_i && act_line && (widx_n < nwords);
    load     = in_word && (boff == '0);
    tidx     = (line_n - IMG_LINES) * WORDS_PER_LINE + widx_n;
    if (line_n < IMG_LINES) begin
      if (line_n == 0 && widx_n == 0)      kind = K_HDR0;
      else if (line_n == 0 && widx_n == 1) kind = K_HDR1;
      else                                 kind = K_IMG;
    end else begin
      if (tidx == 0)             kind = K_CHK0;
      else if (tidx == 1)        kind = K_CHK1;
      else if (tidx < INFO_END)  kind = K_INFO;
      else                       kind = K_ZERO;
    end
  end

  lf_word_source #(
    .IMG_LAST  (IMG_LAST),
    .INFO_FIRST(INFO_FIRST)
  ) u_src (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .kind_i(kind),
    .word_o(word)
  );

  lf_bit_shifter u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(in_word),
    .word_i (word),
    .bit_o  (ser_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_sync_o   <= 1'b0;
      frame_start_o <= 1'b0;
      bit_clk_o     <= 1'b0;
    end else begin
      word_sync_o   <= en_i && act_line && (cyc == '0);
      frame_start_o <= en_i && (line == '0) && (cyc == '0);
      bit_clk_o     <= ~bit_clk_o;
    end
  end

  // R2: free-running bit clock
  p_clk_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (bit_clk_o != $past(bit_clk_o)));

  // R3: sync is a single-cycle pulse
  p_sync_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_sync_o |=> !word_sync_o);

  // R8: frame flag only with a line sync
  p_frame_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> word_sync_o);

  // R9: disabled cycle yields quiet outputs
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!ser_data_o && !word_sync_o && !frame_start_o));
endmodule

// File: tb/lf_image_serializer_test.sv
`timescale 1ns/1ps
module lf_image_serializer_test;
  localparam int WPL   = 4;
  localparam int IMGL  = 3;
  localparam int TRLL  = 2;
  localparam int SLOTS = 7;
  localparam int LCYC  = 100;
  localparam int INFON = 3;
  localparam int ITOP  = 5;
  localparam int IFST  = 2;
  localparam int FRAME = SLOTS * LCYC;

  logic clk = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic ser_data_o, word_sync_o, bit_clk_o, frame_start_o;

  always #2 clk = ~clk;

  lf_image_serializer #(
    .WORDS_PER_LINE(WPL), .IMG_LINES(IMGL), .TRAILER_LINES(TRLL),
    .LINE_SLOTS(SLOTS), .LINE_CYCLES(LCYC), .INFO_WORDS(INFON),
    .IMG_LAST(ITOP), .INFO_FIRST(IFST)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i),
    .ser_data_o(ser_data_o), .word_sync_o(word_sync_o),
    .bit_clk_o(bit_clk_o), .frame_start_o(frame_start_o)
  );

  typedef struct {
    logic  d;
    logic  s;
    logic  f;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side frame model
  int m_c = 0, m_l = 0, m_img = 0, m_info = IFST;
  logic [15:0] m_word = '0;
  string m_tag = "R7";
  string tag_mode = "";

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(logic en);
    exp_t e;
    int widx, off, nw, t;
    bit act;
    if (!en) begin
      e.d = 0; e.s = 0; e.f = 0; e.tag = "R9";
      m_c = 0; m_l = 0;
    end else begin
      act  = m_l < IMGL + TRLL;
      nw   = (m_l == 0) ? WPL + 2 : WPL;
      e.s  = act && m_c == 0;
      e.f  = m_l == 0 && m_c == 0;
      widx = m_c / 16;
      off  = m_c % 16;
      if (act && widx < nw) begin
        if (off == 0) begin
          if (m_l == 0 && widx == 0) begin m_word = 16'hFAF3; m_tag = "R4"; end
          else if (m_l == 0 && widx == 1) begin m_word = 16'hEB90; m_tag = "R4"; end
          else if (m_l < IMGL) begin
            m_word = 16'(m_img); m_tag = "R5";
            m_img  = (m_img == ITOP) ? 0 : m_img + 1;
          end else begin
            t = (m_l - IMGL) * WPL + widx;
            m_tag = "R6";
            if (t == 0)              m_word = 16'h050C;
            else if (t == 1)         m_word = 16'h146F;
            else if (t < 2 + INFON) begin
              m_word = 16'(m_info);
              m_info = (m_info == 0) ? IFST : m_info - 1;
            end else                 m_word = 16'h0000;
          end
          if (tag_mode != "") m_tag = {m_tag, "/", tag_mode};
        end
        e.d   = m_word[15-off];
        e.tag = m_tag;
      end else begin
        e.d = 0; e.tag = "R7";
      end
      m_c++;
      if (m_c == LCYC) begin
        m_c = 0;
        m_l = (m_l + 1) % SLOTS;
        if (m_l == 0) tag_mode = "";
      end
    end
    q.push_back(e);
  endtask

  task automatic run(int n, logic en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en_i = en;
      step(en);
    end
  endtask

  // monitor / scoreboard
  logic prev_clk = 1'b0;
  bit   prev_ok  = 0;
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.tag, ser_data_o, e.d, "data");
      chk("R3", word_sync_o, e.s, "sync");
      chk("R8", frame_start_o, e.f, "frame_start");
    end
    if (rst_ni) begin
      if (prev_ok) chk("R2", bit_clk_o, ~prev_clk, "bit_clk");
      prev_clk = bit_clk_o;
      prev_ok  = 1;
    end else begin
      prev_ok = 0;
    end
  end

  task automatic reset_checks();
    chk("R1", ser_data_o, 1'b0, "data in reset");
    chk("R1", word_sync_o, 1'b0, "sync in reset");
    chk("R1", frame_start_o, 1'b0, "frame_start in reset");
    chk("R1", bit_clk_o, 1'b0, "bit_clk in reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_checks();
    rst_ni = 1'b1;
    run(5, 1'b0);                  // R9: quiet while disabled
    run(2 * FRAME + 350, 1'b1);    // R4 R5 R6 R7 R8 incl. wraps across frames
    run(40, 1'b0);                 // R9: pause mid-frame
    tag_mode = "R9";
    run(FRAME + 10, 1'b1);         // R9: header again, counts resume
    @(negedge clk);
    rst_ni = 1'b0;
    en_i   = 1'b0;
    repeat (2) @(negedge clk);
    reset_checks();
    m_c = 0; m_l = 0; m_img = 0; m_info = IFST;
    tag_mode = "R10";              // R10: counts restart
    rst_ni = 1'b1;
    run(2 * FRAME, 1'b1);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule